// File: doc/BRIEF.md
# DMA Channel Register Front End

This block holds the programming registers and the sequencing core of one DMA channel. Software sees four 32-bit registers: source pointer, destination pointer, transfer length and control. They sit in a 64-byte window that is split into four 16-byte groups. Each group lists the same four registers in a different order, and the last word of every group is a start trigger. A driver can therefore pick the group whose final word is the register it wants to change last. It then starts the channel with the same store that sets that value.

The external datapath reports each finished read and each finished write with a one-cycle pulse. The block moves the pointers forward by the transfer size, counts down the remaining transfers and drops its busy flag when the count runs out. The length register keeps a separate reload value. Every start copies that value into the live counter, so a channel can be started again and again with the same length.

Top module: `dma_alias_regs`

## Requirements
- R1: After reset the pointers, the control fields, the live count, the reload value and busy are all zero.
- R2: The word index is reg_addr[5:2], with the group in bits [5:4] and the slot in bits [3:2]. The slots hold these registers: group 0 has SRC, DST, LEN, CTRL; group 1 has CTRL, SRC, DST, LEN; group 2 has CTRL, LEN, SRC, DST; group 3 has CTRL, DST, LEN, SRC. Every alias of a register reads and writes the same storage.
- R3: A write to slot 3 of any group stores the value. It starts the channel (busy=1) only when the written value is nonzero. A zero write to a trigger slot stores the value and leaves busy unchanged.
- R4: A write to LEN through any alias updates only the reload value. It leaves the live count as it was, also while the channel is busy.
- R5: A trigger copies the reload value into the live count. Each restart repeats the most recently programmed length.
- R6: When the trigger is the LEN alias (address 0x1C), the written value becomes the live count at once and is also stored as the reload value.
- R7: While busy, each wr_done pulse lowers the live count by one. Busy clears on the pulse that takes the count to zero. Reads of LEN return the live count.
- R8: While busy, rd_done advances the source pointer when CTRL bit 2 is set, and wr_done advances the destination pointer when CTRL bit 3 is set. When the bit is clear, or when the channel is idle, the pointer does not move.
- R9: CTRL bits [1:0] give the size: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. A pointer step equals that size.
- R10: A trigger that finds a reload value of zero does not start the channel.
- R11: A nonzero trigger while busy restarts the sequence with the new values.
- R12: CTRL bit 31 reads back busy and ignores writes. CTRL bits [30:4] read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset in the 64-byte window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rd_done | input | 1 | One read transfer finished |
| wr_done | input | 1 | One write transfer finished |
| src_ptr | output | 32 | Next address to read |
| dst_ptr | output | 32 | Next address to write |
| remaining | output | 32 | Live transfer count |
| busy | output | 1 | Channel active |

## Verification
The alias map is tested by writing through one alias and reading back through the others. This shows whether the decode places each register in the correct slot of every group. Starts are tried with a CTRL trigger, with a LEN trigger, with a pointer trigger, with a zero trigger value and with a zero reload value. These cases show whether the live count comes from the reload value or from the written data, and whether a zero value is kept from starting the channel. Transfer pulses are sent both with the increment bits set and with them cleared, at several sizes and while the channel is idle. This shows whether the pointers and the count move only when they should.

// File: rtl/dma_alias_regs.sv
module dma_alias_regs #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rd_done,
  input  logic          wr_done,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] remaining,
  output logic          busy
);
  localparam logic [1:0] SEL_SRC = 2'd0, SEL_DST = 2'd1, SEL_LEN = 2'd2, SEL_CTL = 2'd3;

  logic [3:0]    ctl_q;
  logic [CW-1:0] reload_q;
  logic [1:0]    wsel, rsel;
  logic          go;
  logic [CW-1:0] start_len;
  logic [AW-1:0] step;

  function automatic logic [1:0] decode(input logic [3:0] idx);
    case (idx)
      4'h0: decode = SEL_SRC;  4'h1: decode = SEL_DST;
      4'h2: decode = SEL_LEN;  4'h3: decode = SEL_CTL;
      4'h4: decode = SEL_CTL;  4'h5: decode = SEL_SRC;
      4'h6: decode = SEL_DST;  4'h7: decode = SEL_LEN;
      4'h8: decode = SEL_CTL;  4'h9: decode = SEL_LEN;
      4'hA: decode = SEL_SRC;  4'hB: decode = SEL_DST;
      4'hC: decode = SEL_CTL;  4'hD: decode = SEL_DST;
      4'hE: decode = SEL_LEN;  default: decode = SEL_SRC;
    endcase
  endfunction

  assign wsel      = decode(reg_addr[5:2]);
  assign rsel      = decode(reg_addr[5:2]);
  assign go        = reg_we && (reg_addr[3:2] == 2'd3) && (reg_wdata != 32'd0);
  assign start_len = (wsel == SEL_LEN) ? CW'(reg_wdata) : reload_q;
  assign step      = (ctl_q[1:0] == 2'd0) ? AW'(1) : (ctl_q[1:0] == 2'd1) ? AW'(2) : AW'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ptr   <= '0;
      dst_ptr   <= '0;
      ctl_q     <= '0;
      reload_q  <= '0;
      remaining <= '0;
      busy      <= 1'b0;
    end else begin
      if (reg_we && wsel == SEL_SRC)
        src_ptr <= AW'(reg_wdata);
      else if (busy && rd_done && ctl_q[2])
        src_ptr <= src_ptr + step;

      if (reg_we && wsel == SEL_DST)
        dst_ptr <= AW'(reg_wdata);
      else if (busy && wr_done && ctl_q[3])
        dst_ptr <= dst_ptr + step;

      if (reg_we && wsel == SEL_CTL)
        ctl_q <= reg_wdata[3:0];

      if (reg_we && wsel == SEL_LEN)
        reload_q <= CW'(reg_wdata);

      if (go) begin
        remaining <= start_len;
        busy      <= (start_len != '0);
      end else if (busy && wr_done) begin
        remaining <= remaining - 1'b1;
        if (remaining == CW'(1)) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    case (rsel)
      SEL_SRC: reg_rdata = 32'(src_ptr);
      SEL_DST: reg_rdata = 32'(dst_ptr);
      SEL_LEN: reg_rdata = 32'(remaining);
      default: reg_rdata = {busy, 27'd0, ctl_q};
    endcase
  end
endmodule

module dma_alias_regs_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [5:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          rd_done,
  input logic          wr_done,
  input logic [AW-1:0] src_ptr,
  input logic [CW-1:0] remaining,
  input logic          busy
);
  p_busy_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remaining != '0);
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_done && !reg_we |=> remaining == $past(remaining) - 1'b1);
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(reg_we) |-> $past(wr_done) && $past(remaining) == CW'(1));
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !reg_we |=> $stable(src_ptr));
  p_live_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr == 6'h08 && !wr_done |=> $stable(remaining));
  p_zero_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_we && reg_wdata == 32'd0 |=> !busy);
endmodule

bind dma_alias_regs dma_alias_regs_chk #(.AW(AW), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rd_done(rd_done), .wr_done(wr_done),
  .src_ptr(src_ptr), .remaining(remaining), .busy(busy)
);

// File: tb/test_dma_alias_regs.sv
module test_dma_alias_regs;
  logic clk = 0, rst_n = 0, reg_we = 0, rd_done = 0, wr_done = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [31:0] src_ptr, dst_ptr, remaining;
  logic busy;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_alias_regs i_dma_alias_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_done(rd_done),
    .wr_done(wr_done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .remaining(remaining), .busy(busy));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(bit r, bit w);
    @(negedge clk); rd_done = r; wr_done = w;
    @(negedge clk); rd_done = 0; wr_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin rd(6'(i*4), v); check("R1 reg", v, 0); end
    check("R1 busy", {31'd0, busy}, 0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(6'h00, 32'h1000);
    rd(6'h14, v); check("R2 src g1", v, 32'h1000);
    rd(6'h28, v); check("R2 src g2", v, 32'h1000);
    rd(6'h3C, v); check("R2 src g3", v, 32'h1000);
    wr(6'h34, 32'h2000);
    rd(6'h04, v); check("R2 dst g0", v, 32'h2000);
    rd(6'h18, v); check("R2 dst g1", v, 32'h2000);
    wr(6'h30, 32'h0000_000E);
    rd(6'h0C, v); check("R2 ctl g0", v, 32'hE);
    rd(6'h20, v); check("R2 ctl g2", v, 32'hE);
    check("R3 no start on non-trigger slot", {31'd0, busy}, 0);
  endtask

  task automatic t_reload_run();
    logic [31:0] v;
    wr(6'h08, 3);
    check("R4 live unchanged", remaining, 0);
    wr(6'h0C, 32'hE);
    check("R3 ctl trigger busy", {31'd0, busy}, 1);
    check("R5 live from reload", remaining, 3);
    pulse(1, 0);
    check("R8 src +4", src_ptr, 32'h1004);
    check("R8 dst held on rd_done", dst_ptr, 32'h2000);
    pulse(0, 1);
    check("R8 dst +4", dst_ptr, 32'h2004);
    check("R7 dec", remaining, 2);
    rd(6'h38, v); check("R7 read live", v, 2);
    wr(6'h24, 5);
    check("R4 live kept while busy", remaining, 2);
    pulse(0, 1); pulse(0, 1);
    check("R7 zero", remaining, 0);
    check("R7 busy clear", {31'd0, busy}, 0);
    rd(6'h10, v); check("R12 busy bit clear", v, 32'hE);
    pulse(1, 1);
    check("R8 idle dst hold", dst_ptr, 32'h200C);
    check("R8 idle src hold", src_ptr, 32'h1004);
    check("R7 idle count hold", remaining, 0);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(6'h0C, 32'hE);
    check("R5 repeat last length", remaining, 5);
    rd(6'h0C, v); check("R12 busy bit set", v, 32'h8000_000E);
    pulse(0, 1);
    check("R7 dec", remaining, 4);
    wr(6'h3C, 32'h3000);
    check("R11 restart count", remaining, 5);
    check("R11 restart src", src_ptr, 32'h3000);
    check("R11 busy", {31'd0, busy}, 1);
    wr(6'h1C, 7);
    check("R6 len trigger live", remaining, 7);
    wr(6'h0C, 32'hE);
    check("R6 len trigger reload", remaining, 7);
    for (int i = 0; i < 7; i++) pulse(0, 1);
    check("R7 drained", {31'd0, busy}, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(6'h1C, 0);
    check("R3 zero trigger no start", {31'd0, busy}, 0);
    wr(6'h0C, 32'hE);
    check("R10 zero reload no start", {31'd0, busy}, 0);
    check("R10 count", remaining, 0);
    wr(6'h30, 32'h7FFF_FFF0);
    rd(6'h30, v); check("R12 unmapped zero", v, 0);
  endtask

  task automatic t_size();
    wr(6'h10, 32'h4);
    wr(6'h08, 2);
    wr(6'h00, 32'h100);
    wr(6'h2C, 32'h500);
    check("R3 dst trigger busy", {31'd0, busy}, 1);
    pulse(1, 0);
    check("R9 size 1", src_ptr, 32'h101);
    pulse(0, 1);
    check("R8 dst inc off", dst_ptr, 32'h500);
    wr(6'h20, 32'h9);
    pulse(1, 1);
    check("R9 size 2", dst_ptr, 32'h502);
    check("R8 src inc off", src_ptr, 32'h101);
    check("R7 done", {31'd0, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alias();
    t_reload_run();
    t_restart();
    t_zero();
    t_size();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_run++; n_fail++; $display("FAIL watchdog"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule